// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the register interface that a host bus sees on an audio codec. It has four byte-wide direct locations: an index register, a data window into a bank of 32 indirect control registers, an interrupt status register and a programmed-I/O data port. The host writes an index and then reads or writes the selected indirect register through the data window. The whole indirect bank is exported in parallel to the playback engine. That engine returns a one-cycle pulse when a playback interrupt occurs, and the block raises its interrupt line until the host acknowledges it.

Several registers do not behave as plain storage. How many index bits are decoded depends on a mode bit. The playback format register only accepts writes while one of two mode-change enables is set. Some registers are read-only or reserved. A calibration-in-progress flag counts down as the host polls it. The interrupt can be acknowledged in two ways.

Top module: `codec_regfile`

## Requirements
- R1: After reset the index register reads 0x40, status reads 0x00 and the interrupt line is low. The indirect registers reset as follows: 2,3,4,5,18,19 to 0x88; 6,7 to 0x80; 9 to 0x08; 12 to 0x8A; 25,26 to 0xA0; all others to 0x00.
- R2: A write to direct address 0 stores the written byte with bit 7 cleared. Reads of address 0 return it, so bit 7 always reads 0. Index bit 6 is the mode-change enable (MCE).
- R3: The data window (direct address 1) selects indirect register index[3:0] when bit 6 of register 12 is 0, and index[4:0] when it is 1.
- R4: A write to register 12 changes only its bit 6. The other seven bits keep their value.
- R5: A write to register 8 (playback format) stores the full byte when MCE is 1. When MCE is 0 and bit 0 of register 24 is 1, it replaces only bits 7:4 and keeps bits 3:0. In all other cases it is ignored.
- R6: A write to register 9 stores the byte with bit 5 forced to 0.
- R7: Writes to register 11 (error status, read-only) and to reserved registers 22, 27 and 29 leave them unchanged.
- R8: An index write that takes MCE from 0 to 1 while register 9 bit 3 or bit 4 is 1 loads a calibration counter with CAL_LOAD (default 4). While the counter is nonzero, reads of register 11 return bit 5 set. Each such read decrements the counter.
- R9: An irqSet pulse sets status bit 0 (INT) and register 24 bit 4 (playback flag). From the next cycle irqOut is high.
- R10: Any write to direct address 2 clears INT, clears register 24 bits 6:4 (timer, capture and playback flags) and drops irqOut in the next cycle.
- R11: A write to register 24 stores the byte. If it takes bit 4 from 1 to 0, it also clears INT and irqOut.
- R12: Writes to direct address 3 are ignored, and reads of it return 0x00.
- R13: regsOut carries register n in bits [8n+7:8n] and always matches what the data window would return, apart from the calibration flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Direct address: 0 index, 1 data, 2 status, 3 PIO |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| irqSet | input | 1 | Playback interrupt pulse from the engine |
| irqOut | output | 1 | Interrupt request line |
| regsOut | output | 256 | All indirect registers, 8 bits each |

## Verification
The bench aims at the index width switching when the mode bit flips. A design that always decodes 5 bits would reach register 25 instead of 9. It covers all three branches of the format-write gate. A wrong gate would either overwrite the low nibble under the partial enable or accept writes while locked. It counts the calibration reads one by one, so an off-by-one would show a fifth busy read or only three. It also uses both interrupt acknowledge paths. A write to the flag register that leaves the playback bit set must not drop the line, and a status write must clear all three flags at once.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

  localparam int REG_W    = 8;
  localparam int IND_NUM  = 32;
  localparam int IDX_W    = $clog2(IND_NUM);
  localparam int NARROW_W = 4;
  localparam int IDXREG_W = REG_W - 1;

  // indirect register positions decoded by software
  localparam int IX_FMT  = 8;
  localparam int IX_IFC  = 9;
  localparam int IX_ERR  = 11;
  localparam int IX_MODE = 12;
  localparam int IX_AFS  = 24;
  localparam int IX_RSV0 = 22;
  localparam int IX_RSV1 = 27;
  localparam int IX_RSV2 = 29;

  // bit positions
  localparam int MCE_BIT   = 6;
  localparam int MODE2_BIT = 6;
  localparam int PMCE_BIT  = 0;
  localparam int PI_BIT    = 4;
  localparam int CAL_BIT   = 5;
  localparam int INT_BIT   = 0;

  localparam logic [REG_W-1:0] IFC_ZERO_MASK = 8'h20;
  localparam logic [REG_W-1:0] MODE2_MASK    = 8'h40;
  localparam logic [REG_W-1:0] AFS_FLAGS     = 8'h70;
  localparam logic [REG_W-1:0] PIO_IDLE      = 8'h00;

  typedef enum logic [1:0] {
    DA_INDEX  = 2'd0,
    DA_DATA   = 2'd1,
    DA_STATUS = 2'd2,
    DA_PIO    = 2'd3
  } dirAddr_e;

  typedef struct packed {
    logic             idxWr;
    logic             indWr;
    logic [IDX_W-1:0] indSel;
    logic             statWr;
    logic             calLoad;
    logic             calDec;
  } strobes_t;

  function automatic logic [REG_W-1:0] resetVal(input int idx);
    case (idx)
      2, 3, 4, 5, 18, 19: resetVal = 8'h88;
      6, 7:               resetVal = 8'h80;
      9:                  resetVal = 8'h08;
      12:                 resetVal = 8'h8A;
      25, 26:             resetVal = 8'hA0;
      default:            resetVal = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/codec_regs_ctrl.sv
module codec_regs_ctrl
  import codec_regs_pkg::*;
(
  input  logic [1:0]       busAddr,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic             mceNew,
  input  logic [IDX_W-1:0] idxLow,
  input  logic             mceNow,
  input  logic             mode2,
  input  logic [1:0]       ifcCal,
  input  logic             calBusy,
  output logic [IDX_W-1:0] curSel,
  output strobes_t         stb
);

  dirAddr_e addrKind;
  assign addrKind = dirAddr_e'(busAddr);

  // index width follows the mode bit
  always_comb begin
    if (mode2) curSel = idxLow;
    else       curSel = {{(IDX_W-NARROW_W){1'b0}}, idxLow[NARROW_W-1:0]};
  end

  always_comb begin
    stb         = '0;
    stb.indSel  = curSel;
    stb.idxWr   = busWrEn && (addrKind == DA_INDEX);
    stb.indWr   = busWrEn && (addrKind == DA_DATA);
    stb.statWr  = busWrEn && (addrKind == DA_STATUS);
    stb.calLoad = stb.idxWr && !mceNow && mceNew && (|ifcCal);
    stb.calDec  = busRdEn && (addrKind == DA_DATA)
                  && (curSel == IDX_W'(IX_ERR)) && calBusy;
  end

endmodule

// File: rtl/codec_regs_dp.sv
module codec_regs_dp
  import codec_regs_pkg::*;
#(
  parameter int CAL_LOAD = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 stb,
  input  logic [1:0]               busAddr,
  input  logic [REG_W-1:0]         busWrData,
  input  logic                     irqSet,
  input  logic [IDX_W-1:0]         curSel,
  output logic [IDXREG_W-1:0]      indexReg,
  output logic                     mode2,
  output logic [1:0]               ifcCal,
  output logic                     calBusy,
  output logic [REG_W-1:0]         busRdData,
  output logic                     irqOut,
  output logic [IND_NUM*REG_W-1:0] regsOut
);

  localparam int CNT_W = $clog2(CAL_LOAD + 1);

  logic [IND_NUM-1:0][REG_W-1:0] regVal;
  logic                          intFlag;
  logic [CNT_W-1:0]              calCnt;
  logic                          mceNow;
  logic                          piFall;

  assign mceNow = indexReg[MCE_BIT];

  // index register, bit 7 never stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          indexReg <= IDXREG_W'(8'h40);
    else if (stb.idxWr) indexReg <= busWrData[IDXREG_W-1:0];
  end

  // indirect bank, one variant per register kind
  for (genvar g = 0; g < IND_NUM; g++) begin : g_reg
    logic [REG_W-1:0] q;
    logic [REG_W-1:0] nxt;
    logic             hit;

    assign hit = stb.indWr && (stb.indSel == IDX_W'(g));

    if (g == IX_FMT) begin : g_fmt
      always_comb begin
        nxt = q;
        if (hit) begin
          if (mceNow)
            nxt = busWrData;
          else if (regVal[IX_AFS][PMCE_BIT])
            nxt = {busWrData[REG_W-1:4], q[3:0]};
        end
      end
    end else if (g == IX_IFC) begin : g_ifc
      always_comb nxt = hit ? (busWrData & ~IFC_ZERO_MASK) : q;
    end else if (g == IX_ERR || g == IX_RSV0 || g == IX_RSV1 || g == IX_RSV2) begin : g_ro
      always_comb nxt = q;
    end else if (g == IX_MODE) begin : g_mode
      always_comb nxt = hit ? ((q & ~MODE2_MASK) | (busWrData & MODE2_MASK)) : q;
    end else if (g == IX_AFS) begin : g_afs
      always_comb begin
        nxt = hit ? busWrData : q;
        if (stb.statWr) nxt = nxt & ~AFS_FLAGS;
        if (irqSet)     nxt[PI_BIT] = 1'b1;
      end
    end else begin : g_plain
      always_comb nxt = hit ? busWrData : q;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= resetVal(g);
      else       q <= nxt;
    end

    assign regVal[g] = q;
  end

  assign regsOut = regVal;
  assign mode2   = regVal[IX_MODE][MODE2_BIT];
  assign ifcCal  = regVal[IX_IFC][4:3];

  // interrupt flag: a new event wins over an acknowledge
  assign piFall = stb.indWr && (stb.indSel == IDX_W'(IX_AFS))
                  && regVal[IX_AFS][PI_BIT] && !busWrData[PI_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     intFlag <= 1'b0;
    else if (irqSet)               intFlag <= 1'b1;
    else if (stb.statWr || piFall) intFlag <= 1'b0;
  end

  assign irqOut = intFlag;

  // calibration countdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            calCnt <= '0;
    else if (stb.calLoad) calCnt <= CNT_W'(CAL_LOAD);
    else if (stb.calDec)  calCnt <= calCnt - 1'b1;
  end

  assign calBusy = (calCnt != '0);

  // read mux
  always_comb begin
    case (dirAddr_e'(busAddr))
      DA_INDEX:  busRdData = {1'b0, indexReg};
      DA_DATA: begin
        busRdData = regVal[curSel];
        if (curSel == IDX_W'(IX_ERR) && calBusy) busRdData[CAL_BIT] = 1'b1;
      end
      DA_STATUS: begin
        busRdData          = '0;
        busRdData[INT_BIT] = intFlag;
      end
      default:   busRdData = PIO_IDLE;
    endcase
  end

endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_regs_pkg::*;
#(
  parameter int CAL_LOAD = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               busAddr,
  input  logic                     busWrEn,
  input  logic                     busRdEn,
  input  logic [REG_W-1:0]         busWrData,
  output logic [REG_W-1:0]         busRdData,
  input  logic                     irqSet,
  output logic                     irqOut,
  output logic [IND_NUM*REG_W-1:0] regsOut
);

  strobes_t              stb;
  logic [IDXREG_W-1:0]   indexReg;
  logic [IDX_W-1:0]      curSel;
  logic                  mode2;
  logic [1:0]            ifcCal;
  logic                  calBusy;

  codec_regs_ctrl i_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .mceNew  (busWrData[MCE_BIT]),
    .idxLow  (indexReg[IDX_W-1:0]),
    .mceNow  (indexReg[MCE_BIT]),
    .mode2   (mode2),
    .ifcCal  (ifcCal),
    .calBusy (calBusy),
    .curSel  (curSel),
    .stb     (stb)
  );

  codec_regs_dp #(.CAL_LOAD(CAL_LOAD)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .irqSet    (irqSet),
    .curSel    (curSel),
    .indexReg  (indexReg),
    .mode2     (mode2),
    .ifcCal    (ifcCal),
    .calBusy   (calBusy),
    .busRdData (busRdData),
    .irqOut    (irqOut),
    .regsOut   (regsOut)
  );

endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk
  import codec_regs_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [1:0]               busAddr,
  input logic                     busWrEn,
  input logic [REG_W-1:0]         busWrData,
  input logic [REG_W-1:0]         busRdData,
  input logic                     irqSet,
  input logic                     irqOut,
  input logic [IND_NUM*REG_W-1:0] regsOut,
  input logic [IDXREG_W-1:0]      indexReg
);

  logic [IDX_W-1:0] selNow;
  logic             dataWr;

  assign selNow = regsOut[IX_MODE*REG_W + MODE2_BIT] ? indexReg[IDX_W-1:0]
                                                     : {1'b0, indexReg[NARROW_W-1:0]};
  assign dataWr = busWrEn && (busAddr == 2'd1);

  // R2
  a_r2_idx_bit7: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0) |-> !busRdData[7]);

  // R9
  a_r9_irq_set: assert property (@(posedge clk) disable iff (!rstN)
    irqSet |=> (irqOut && regsOut[IX_AFS*REG_W + PI_BIT]));

  // R10
  a_r10_stat_ack: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd2 && !irqSet) |=>
      (!irqOut && regsOut[IX_AFS*REG_W + 4 +: 3] == 3'b000));

  // R6
  a_r6_ifc_bit5: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> !regsOut[IX_IFC*REG_W + 5]);

  // R7
  a_r7_err_ro: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> $stable(regsOut[IX_ERR*REG_W +: REG_W]));

  // R4
  a_r4_mode_bits: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> $stable(regsOut[IX_MODE*REG_W +: REG_W] & ~MODE2_MASK));

  // R5
  a_r5_fmt_locked: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && selNow == IDX_W'(IX_FMT) && !indexReg[MCE_BIT]
      && !regsOut[IX_AFS*REG_W + PMCE_BIT])
      |=> $stable(regsOut[IX_FMT*REG_W +: REG_W]));

  // R11
  a_r11_pi_fall: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && selNow == IDX_W'(IX_AFS) && !irqSet && !busWrData[PI_BIT]
      && regsOut[IX_AFS*REG_W + PI_BIT]) |=> !irqOut);

endmodule

bind codec_regfile codec_regfile_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .irqSet    (irqSet),
  .irqOut    (irqOut),
  .regsOut   (regsOut),
  .indexReg  (indexReg)
);

// File: tb/test_codec_regfile.sv
module test_codec_regfile;

  localparam int CAL = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   busAddr = 2'd0;
  logic         busWrEn = 1'b0;
  logic         busRdEn = 1'b0;
  logic [7:0]   busWrData = 8'h00;
  logic [7:0]   busRdData;
  logic         irqSet = 1'b0;
  logic         irqOut;
  logic [255:0] regsOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] mReg [32];
  logic [7:0] mIdx;
  bit         mInt;
  int         mCal;

  always #4 clk = ~clk;

  codec_regfile #(.CAL_LOAD(CAL)) i_codec_regfile (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqSet(irqSet), .irqOut(irqOut), .regsOut(regsOut)
  );

  function automatic logic [7:0] expReset(int n);
    if (n inside {2, 3, 4, 5, 18, 19}) return 8'h88;
    if (n == 6 || n == 7) return 8'h80;
    if (n == 9) return 8'h08;
    if (n == 12) return 8'h8A;
    if (n == 25 || n == 26) return 8'hA0;
    return 8'h00;
  endfunction

  function automatic int mSel();
    return mReg[12][6] ? int'(mIdx[4:0]) : int'(mIdx[3:0]);
  endfunction

  function automatic logic [7:0] mRead(logic [1:0] a);
    logic [7:0] v;
    case (a)
      2'd0: v = mIdx;
      2'd1: begin
        v = mReg[mSel()];
        if (mSel() == 11 && mCal > 0) v[5] = 1'b1;
      end
      2'd2: v = {7'b0, mInt};
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  task automatic mWrite(logic [1:0] a, logic [7:0] d);
    int s;
    case (a)
      2'd0: begin
        if (!mIdx[6] && d[6] && (mReg[9][4:3] != 2'b00)) mCal = CAL;
        mIdx = d & 8'h7F;
      end
      2'd1: begin
        s = mSel();
        case (s)
          8: begin
            if (mIdx[6]) mReg[8] = d;
            else if (mReg[24][0]) mReg[8] = {d[7:4], mReg[8][3:0]};
          end
          9: mReg[9] = d & 8'hDF;
          11, 22, 27, 29: ;
          12: mReg[12][6] = d[6];
          24: begin
            if (mReg[24][4] && !d[4]) mInt = 0;
            mReg[24] = d;
          end
          default: mReg[s] = d;
        endcase
      end
      2'd2: begin
        mInt = 0;
        mReg[24][6:4] = 3'b000;
      end
      default: ;
    endcase
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic checkRegs(string req);
    int bad;
    bad = -1;
    checks++;
    for (int n = 31; n >= 0; n--)
      if (regsOut[n*8 +: 8] !== mReg[n]) bad = n;
    if (bad >= 0) begin
      failures++;
      $display("FAIL %s reg%0d actual=%02h expected=%02h", req, bad,
               regsOut[bad*8 +: 8], mReg[bad]);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    mWrite(a, d);
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v, output logic [7:0] e);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1;
    v = busRdData;
    e = mRead(a);
    @(negedge clk);
    busRdEn = 1'b0;
    if (a == 2'd1 && mSel() == 11 && mCal > 0) mCal--;
  endtask

  task automatic pulseIrq();
    @(negedge clk);
    irqSet = 1'b1;
    @(negedge clk);
    irqSet = 1'b0;
    mInt = 1;
    mReg[24][4] = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, e;
    for (int n = 0; n < 32; n++) mReg[n] = expReset(n);
    mIdx = 8'h40; mInt = 0; mCal = 0;
    void'($urandom(32'h00C0DEC5));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v, e); check("R1 index reset", v, 8'h40);
    rd(2'd2, v, e); check("R1 status reset", v, 8'h00);
    check("R1 irq reset", {7'b0, irqOut}, 8'h00);
    checkRegs("R1 bank reset");

    // R3 narrow index, R2 bit 7 dropped
    wr(2'd0, 8'h99);
    rd(2'd0, v, e); check("R2 index bit7", v, 8'h19);
    rd(2'd1, v, e); check("R3 narrow select", v, 8'h08);
    // R4 only mode bit changes
    wr(2'd0, 8'h0C); wr(2'd1, 8'hFF);
    rd(2'd1, v, e); check("R4 mode write", v, 8'hCA);
    wr(2'd0, 8'h19);
    rd(2'd1, v, e); check("R3 wide select", v, 8'hA0);

    // R6
    wr(2'd0, 8'h09); wr(2'd1, 8'hFF);
    rd(2'd1, v, e); check("R6 ifc bit5", v, 8'hDF);

    // R5 three gating branches
    wr(2'd0, 8'h48); wr(2'd1, 8'hA5);
    rd(2'd1, v, e); check("R5 full write", v, 8'hA5);
    wr(2'd0, 8'h08); wr(2'd1, 8'h3C);
    rd(2'd1, v, e); check("R5 locked", v, 8'hA5);
    wr(2'd0, 8'h18); wr(2'd1, 8'h01);
    wr(2'd0, 8'h08); wr(2'd1, 8'h3C);
    rd(2'd1, v, e); check("R5 upper nibble", v, 8'h35);

    // R8 calibration countdown
    wr(2'd0, 8'h00); wr(2'd0, 8'h4B);
    for (int k = 0; k < CAL; k++) begin
      rd(2'd1, v, e); check("R8 cal busy", v, 8'h20);
    end
    rd(2'd1, v, e); check("R8 cal done", v, 8'h00);

    // R7 read-only and reserved
    wr(2'd1, 8'hFF);
    rd(2'd1, v, e); check("R7 err ro", v, 8'h00);
    wr(2'd0, 8'h16); wr(2'd1, 8'h55);
    rd(2'd1, v, e); check("R7 reserved", v, 8'h00);

    // R9 interrupt set
    pulseIrq();
    check("R9 irq high", {7'b0, irqOut}, 8'h01);
    rd(2'd2, v, e); check("R9 status int", v, 8'h01);
    wr(2'd0, 8'h18);
    rd(2'd1, v, e); check("R9 afs flag", v, 8'h11);

    // R11 playback flag fall acknowledges
    wr(2'd1, 8'h01);
    check("R11 ack by afs", {7'b0, irqOut}, 8'h00);
    pulseIrq();
    wr(2'd1, 8'h71);
    check("R11 kept set", {7'b0, irqOut}, 8'h01);

    // R10 status write acknowledge
    wr(2'd2, 8'hFF);
    check("R10 irq low", {7'b0, irqOut}, 8'h00);
    rd(2'd1, v, e); check("R10 afs cleared", v, 8'h01);

    // R12 PIO
    wr(2'd3, 8'hAA);
    rd(2'd3, v, e); check("R12 pio read", v, 8'h00);
    checkRegs("R12 pio no effect");
    checkRegs("R13 export");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [1:0] a;
      logic [7:0] d;
      op = int'($urandom % 10);
      a  = 2'($urandom % 4);
      d  = 8'($urandom);
      if (op < 5) wr(a, d);
      else if (op < 9) begin
        rd(a, v, e); check("R13 random read", v, e);
      end else pulseIrq();
      check("R9 random irq", {7'b0, irqOut}, {7'b0, mInt});
      checkRegs("R13 random export");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule